// File: doc/BRIEF.md
# Guarded APB Register Slave

This block is a small APB subordinate holding five 32-bit register slots. It answers reads and writes through the usual setup/access handshake. While the access phase is active it judges whether each write is legal. A write found illegal still completes on the normal completion edge and raises the one-bit error response. The write enable of every register is qualified by the same judgement, so the rejected value never reaches storage and there is nothing to undo afterwards.

Four conditions make a write illegal:
- an offset past the last slot;
- a write to the read-only status slot;
- a write to the guarded slot with protection attributes that do not grant privileged, secure access;
- a write to the program slot whose simulated program/erase operation fails.

The program slot stretches its writes by a parameterised number of wait states. The outcome of the operation is known before ready rises, so the error and the withheld commit fall on the same edge. The error carries no cause code; software works out the cause from the map itself.

Top module: `apb_guarded_regs`

## Requirements
- R1: While `rst_n` is low at a rising edge (synchronous, active low), slots CTRL_A (0x00), CTRL_B (0x04), GUARD (0x0C) and PROG (0x10) clear to zero. Outside the access phase, `bus_err` is 0 and `bus_ready` is 1.
- R2: A transfer completes on the cycle where `bus_sel`, `bus_enable` and `bus_ready` are all high. A write to CTRL_A or CTRL_B completes with `bus_err` 0 and stores `bus_wdata`, and a later read returns that value.
- R3: `bus_err` is high only on a completion cycle. It is 0 in the setup phase and in every wait cycle.
- R4: Any access to a word index of 5 or more (offset 0x14 and above) completes with `bus_err` 1. Such a write changes nothing, and such a read returns 0 on `bus_rdata`.
- R5: STATUS (0x08) is read-only and reads as `{STATUS_TAG[7:0] in bits 31:24, zeros, bit0 = (PROG != 0)}`. A write to it completes with `bus_err` 1 and has no effect.
- R6: A write to GUARD (0x0C) is accepted only when `bus_prot[0]` is 1 (privileged) and `bus_prot[1]` is 0 (secure). Any other write to GUARD completes with `bus_err` 1 and leaves it unchanged. Reads of GUARD succeed under any protection value.
- R7: A write to PROG holds `bus_ready` low for exactly WAIT_STATES access cycles (default 3). Every other access, including reads of PROG, completes in its first access cycle.
- R8: A PROG write whose `bus_wdata[31]` is 1 models a failed program/erase operation. It completes with `bus_err` 1 and PROG keeps its value. With bit 31 at 0, the write commits.
- R9: A write that completes with `bus_err` 1 leaves every slot unchanged, and a read that follows it at once returns the old value. Reads never change any slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Subordinate select |
| bus_enable | input | 1 | Access-phase marker |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits [ADDR_W-1:2] pick the word |
| bus_wdata | input | DATA_W | Write data |
| bus_prot | input | 3 | Protection attributes: bit0 privileged, bit1 non-secure |
| bus_rdata | output | DATA_W | Read data, valid on a read's completion cycle |
| bus_ready | output | 1 | Completion / wait-state control |
| bus_err | output | 1 | Error response on the completion cycle |

## Verification
The in-RTL assertions watch, on every cycle, that the error bit appears only when the transfer completes, that the slots hold still after any erroring write or any read, that unmapped reads return zero with an error, that writes to the status slot always error, and that only PROG writes ever stall. The bench's behavioural model is needed to show the rest. That covers the exact wait-state count, that legal writes really store their data, the protection decode for GUARD, the pass/fail rule of the program operation, the status bit that follows PROG, and the values seen after a reset in mid-run.

// File: rtl/agr_pkg.sv
// Package agr_pkg
// Shared slot map and fault record for the guarded register slave.
// Assumes a word-addressed map of NUM_SLOTS slots starting at offset 0.
package agr_pkg;

    localparam int NUM_SLOTS = 5;

    // Slot order is what the address decode uses: word index = slot number.
    typedef enum logic [2:0] {
        SLOT_CTRL_A = 3'd0,
        SLOT_CTRL_B = 3'd1,
        SLOT_STATUS = 3'd2,
        SLOT_GUARD  = 3'd3,
        SLOT_PROG   = 3'd4
    } slot_e;

    // One flag per reason a transfer is refused.
    typedef struct packed {
        logic unmapped;
        logic read_only;
        logic prot_deny;
        logic op_fail;
    } fault_t;

    function automatic logic fault_any(input fault_t f);
        return f.unmapped | f.read_only | f.prot_deny | f.op_fail;
    endfunction

endpackage

// File: rtl/agr_legality.sv
// Module agr_legality
// Purely combinational legality judge for one transfer.
// Assumes the word index is already stripped of byte-lane bits. The op_fail
// input is the simulated program/erase outcome for the data being written.
module agr_legality
    import agr_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic [IDX_W-1:0] word_idx,
    input  logic             is_write,
    input  logic             priv,
    input  logic             nonsecure,
    input  logic             op_fail_bit,
    output slot_e            slot,
    output logic             mapped,
    output fault_t           fault,
    output logic             bad
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SLOTS - 1);

    // Decode the slot and classify every refusal reason.
    always_comb begin
        mapped          = (word_idx <= LAST_IDX);
        slot            = mapped ? slot_e'(word_idx[2:0]) : SLOT_CTRL_A;
        fault.unmapped  = !mapped;
        fault.read_only = is_write && mapped && (slot == SLOT_STATUS);
        fault.prot_deny = is_write && mapped && (slot == SLOT_GUARD)
                          && !(priv && !nonsecure);
        fault.op_fail   = is_write && mapped && (slot == SLOT_PROG) && op_fail_bit;
        bad             = fault_any(fault);
    end

endmodule

// File: rtl/agr_wait_gen.sv
// Module agr_wait_gen
// Stretches an access by WAIT_STATES cycles when asked to.
// Assumes need_wait stays steady through the access phase (bus rule).
module agr_wait_gen #(
    parameter int WAIT_STATES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic need_wait,
    output logic ready
);

    localparam int CNT_W = $clog2(WAIT_STATES + 2);
    localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(WAIT_STATES);

    logic [CNT_W-1:0] cnt_q;

    // Ready is high unless a stalled access has not yet served its wait cycles.
    always_comb begin
        ready = !need_wait || (cnt_q == CNT_DONE);
    end

    // Count stalled cycles; clear once the access finishes or nothing waits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (need_wait && !ready) begin
            cnt_q <= cnt_q + 1'b1;
        end else begin
            cnt_q <= '0;
        end
    end

endmodule

// File: rtl/agr_reg_bank.sv
// Module agr_reg_bank
// Storage for the writable slots plus the computed read-only status word.
// Assumes commit is already qualified by legality; no other path writes.
module agr_reg_bank
    import agr_pkg::*;
#(
    parameter int          DATA_W     = 32,
    parameter logic [7:0]  STATUS_TAG = 8'hA5
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             commit,
    input  slot_e                            slot,
    input  logic [DATA_W-1:0]                wdata,
    output logic [NUM_SLOTS-1:0][DATA_W-1:0] regs_o
);

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        if (i == int'(SLOT_STATUS)) begin : g_ro
            // Status word: identity tag on top, bit0 shows PROG holds data.
            assign regs_o[i] = {STATUS_TAG, {(DATA_W - 9){1'b0}},
                                (regs_o[int'(SLOT_PROG)] != '0)};
        end else begin : g_rw
            logic [DATA_W-1:0] cell_q;

            // Capture write data only on a qualified commit to this slot.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cell_q <= '0;
                end else if (commit && (slot == slot_e'(3'(i)))) begin
                    cell_q <= wdata;
                end
            end

            assign regs_o[i] = cell_q;
        end
    end

endmodule

// File: rtl/agr_read_mux.sv
// Module agr_read_mux
// Selects the read word; returns zero for unmapped or non-read cycles.
// Assumes slot is only meaningful when mapped is high.
module agr_read_mux
    import agr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [NUM_SLOTS-1:0][DATA_W-1:0] regs,
    input  slot_e                            slot,
    input  logic                             mapped,
    input  logic                             rd_en,
    output logic [DATA_W-1:0]                rdata
);

    // Drive the chosen slot during a read access, zero otherwise.
    always_comb begin
        rdata = (rd_en && mapped) ? regs[int'(slot)] : '0;
    end

endmodule

// File: rtl/apb_guarded_regs.sv
// Module apb_guarded_regs
// APB subordinate with five slots whose write enables are gated by legality.
// A refused write completes normally with bus_err high and commits nothing.
// Assumes the manager holds address, data and attributes stable through
// setup and access, as the bus requires.
module apb_guarded_regs
    import agr_pkg::*;
#(
    parameter int         DATA_W      = 32,
    parameter int         ADDR_W      = 8,
    parameter int         WAIT_STATES = 3,
    parameter int         FAIL_BIT    = DATA_W - 1,
    parameter logic [7:0] STATUS_TAG  = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_enable,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [2:0]        bus_prot,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ready,
    output logic              bus_err
);

    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]                 word_idx;
    logic                             access;
    logic                             done;
    logic                             need_wait;
    logic                             wait_ready;
    logic                             commit;
    logic                             mapped;
    logic                             bad;
    slot_e                            slot;
    fault_t                           fault;
    logic [NUM_SLOTS-1:0][DATA_W-1:0] reg_view;
    logic                             unused_bits;

    assign word_idx    = bus_addr[ADDR_W-1:2];
    assign unused_bits = ^{bus_addr[1:0], bus_prot[2], fault};

    agr_legality #(.IDX_W(IDX_W)) u_legal (
        .word_idx    (word_idx),
        .is_write    (bus_write),
        .priv        (bus_prot[0]),
        .nonsecure   (bus_prot[1]),
        .op_fail_bit (bus_wdata[FAIL_BIT]),
        .slot        (slot),
        .mapped      (mapped),
        .fault       (fault),
        .bad         (bad)
    );

    // Phase decode, completion and the qualified commit.
    always_comb begin
        access    = bus_sel && bus_enable;
        need_wait = access && bus_write && mapped && (slot == SLOT_PROG);
        bus_ready = wait_ready;
        done      = access && wait_ready;
        bus_err   = done && bad;
        commit    = done && bus_write && !bad;
    end

    agr_wait_gen #(.WAIT_STATES(WAIT_STATES)) u_wait (
        .clk       (clk),
        .rst_n     (rst_n),
        .need_wait (need_wait),
        .ready     (wait_ready)
    );

    agr_reg_bank #(.DATA_W(DATA_W), .STATUS_TAG(STATUS_TAG)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (commit),
        .slot   (slot),
        .wdata  (bus_wdata),
        .regs_o (reg_view)
    );

    agr_read_mux #(.DATA_W(DATA_W)) u_rmux (
        .regs   (reg_view),
        .slot   (slot),
        .mapped (mapped),
        .rd_en  (access && !bus_write),
        .rdata  (bus_rdata)
    );

    // Error may only show when the bus sees a completion.
    assert_err_on_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (bus_sel && bus_enable && bus_ready));

    // A refused write leaves every slot as it was.
    assert_fault_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_enable && bus_ready && bus_write && bus_err) |=> $stable(reg_view));

    // Reads never alter storage.
    assert_read_still_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_enable && bus_ready && !bus_write) |=> $stable(reg_view));

    // Unmapped reads error and return zero.
    assert_unmapped_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_enable && bus_ready && !bus_write
         && (word_idx >= IDX_W'(NUM_SLOTS))) |-> (bus_err && (bus_rdata == '0)));

    // Status slot refuses every write.
    assert_status_ro_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_enable && bus_ready && bus_write
         && (word_idx == IDX_W'(2))) |-> bus_err);

    // Only PROG writes may stall the bus.
    assert_fast_path_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_enable && !(bus_write && (word_idx == IDX_W'(4)))) |-> bus_ready);

endmodule

// File: tb/apb_guarded_regs_bench.sv
// Bench for apb_guarded_regs: behavioural model of the slot map, checked on
// every transfer phase and on every idle clock.
module apb_guarded_regs_bench;

    localparam int WS = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_enable = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [2:0]  bus_prot = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready;
    logic        bus_err;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;
    logic [31:0] mreg [5];

    always #10 clk = ~clk;

    apb_guarded_regs #(.WAIT_STATES(WS)) u_apb_guarded_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_enable(bus_enable),
        .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_prot(bus_prot), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .bus_err(bus_err)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] model_status();
        return {8'hA5, 23'd0, (mreg[4] != 32'd0)};
    endfunction

    task automatic model_clear();
        for (int i = 0; i < 5; i++) mreg[i] = '0;
    endtask

    // Idle cycles: no error, ready high (R1, R3), sampled mid-high phase.
    always @(posedge clk) begin
        #5;
        if (rst_n && !finished && !(bus_sel && bus_enable)) begin
            check(bus_err == 1'b0, "R3 idle/setup err", {31'd0, bus_err}, 32'd0);
            check(bus_ready == 1'b1, "R1 idle ready", {31'd0, bus_ready}, 32'd1);
        end
    end

    task automatic xfer(input bit wr, input logic [7:0] addr, input logic [31:0] data,
                        input logic [2:0] prot, input string req);
        int idx;
        bit mapped;
        bit bad;
        int exp_w;
        int waits;
        logic [31:0] exp_rd;
        idx    = int'(addr[7:2]);
        mapped = idx < 5;
        bad    = !mapped || (wr && (idx == 2 || (idx == 3 && !(prot[0] && !prot[1]))
                                   || (idx == 4 && data[31])));
        exp_w  = (wr && idx == 4) ? WS : 0;
        exp_rd = (!wr && mapped) ? ((idx == 2) ? model_status() : mreg[idx]) : 32'd0;

        @(negedge clk);
        bus_sel = 1'b1; bus_enable = 1'b0; bus_write = wr;
        bus_addr = addr; bus_wdata = data; bus_prot = prot;
        @(negedge clk);
        bus_enable = 1'b1;
        #1;
        waits = 0;
        while (!bus_ready && waits < 64) begin
            check(bus_err == 1'b0, "R3 wait-cycle err", {31'd0, bus_err}, 32'd0);
            @(negedge clk);
            #1;
            waits++;
        end
        check(waits == exp_w, "R7 wait count", waits, exp_w);
        check(bus_err == bad, req, {31'd0, bus_err}, {31'd0, bad});
        if (!wr) check(bus_rdata == exp_rd, req, bus_rdata, exp_rd);
        @(negedge clk);
        bus_sel = 1'b0; bus_enable = 1'b0;
        if (wr && !bad) mreg[idx] = data;
    endtask

    task automatic read_all(input string req);
        for (int i = 0; i < 5; i++) xfer(1'b0, 8'(i * 4), 32'd0, 3'b000, req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_clear();
    endtask

    initial begin
        model_clear();
        do_reset();
        read_all("R1 reset value");

        xfer(1'b1, 8'h00, 32'hDEAD_BEEF, 3'b000, "R2 ctrl_a write");
        xfer(1'b1, 8'h04, 32'h0000_00FF, 3'b010, "R2 ctrl_b write");
        read_all("R2 readback");

        xfer(1'b1, 8'h08, 32'h1234_5678, 3'b001, "R5 status write");
        xfer(1'b0, 8'h08, 32'd0, 3'b000, "R5 status read");

        xfer(1'b1, 8'h14, 32'h5555_AAAA, 3'b001, "R4 unmapped write");
        xfer(1'b1, 8'hFC, 32'hFFFF_FFFF, 3'b001, "R4 top unmapped write");
        xfer(1'b0, 8'h18, 32'd0, 3'b000, "R4 unmapped read");
        read_all("R9 after unmapped writes");

        xfer(1'b1, 8'h0C, 32'h0BAD_0001, 3'b000, "R6 guard unprivileged");
        xfer(1'b1, 8'h0C, 32'h0BAD_0002, 3'b011, "R6 guard nonsecure");
        xfer(1'b0, 8'h0C, 32'd0, 3'b010, "R6 guard read any prot");
        xfer(1'b1, 8'h0C, 32'h600D_0003, 3'b001, "R6 guard permitted");
        xfer(1'b0, 8'h0C, 32'd0, 3'b000, "R6 guard readback");

        xfer(1'b1, 8'h10, 32'h0000_1234, 3'b000, "R8 prog pass");
        xfer(1'b0, 8'h08, 32'd0, 3'b000, "R5 status follows prog");
        xfer(1'b1, 8'h10, 32'h8000_0001, 3'b000, "R8 prog fail");
        xfer(1'b0, 8'h10, 32'd0, 3'b000, "R9 prog kept after fail");
        xfer(1'b1, 8'h10, 32'h7FFF_FFFF, 3'b000, "R8 prog pass max");

        xfer(1'b1, 8'h00, 32'h1111_2222, 3'b000, "R2 ctrl_a overwrite");
        xfer(1'b1, 8'h0C, 32'hFEED_FACE, 3'b100, "R6 guard denied again");
        xfer(1'b0, 8'h0C, 32'd0, 3'b000, "R9 read right after refused");
        read_all("R9 full map");

        do_reset();
        read_all("R1 reset mid-run");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule